// File: doc/BRIEF.md
# Code-Flow Watchdog with Secure Counter

This block watches that firmware walks through its code in the intended order. Firmware arms it by writing a start value. That write loads a secure counter and starts a down-counting instruction timer from a programmed reload value. As execution passes through checkpoints, firmware adjusts the secure counter. Some checkpoint registers add or subtract the written value. Others move the counter by a fixed step of 1, 16 or 256 on any write.

At a restart checkpoint, firmware writes the counter value it expects. A match reloads the timer and the run continues. At the end of the protected region, a stop write makes the same comparison and returns the block to idle. If control flow deviates, the counter no longer matches. If the code stalls, the timer runs out.

Six fault classes are detected: timeout, miscompare, sequence, control, state and address. Each class sets its own sticky flag, and each class has its own programmable response: none, a reset request or an interrupt request. A control word selects these responses. The same word can freeze the timer while a pause input or a debug-halt input is high, and it can be locked until the next reset. A general persistent word is also provided. The block only raises its request outputs; acting on them is left to the surrounding system.

Top module: `cflow_wdog`

## Requirements
- R1: After reset, FLAGS reads 0x40 (only the power-on flag, bit 6), CONTROL reads 0x9249 (every action field = 1, pause/halt/lock bits 0), and both request outputs are low.
- R2: A write to START (offset 2) in idle loads the secure counter with the written data and the timer from RELOAD (offset 1), and makes the block active. A START write while active is ignored and sets the state flag (FLAGS bit 4).
- R3: While active and not frozen, the timer (readable at offset 15) decrements once per cycle. On the first cycle it is found at zero, the timeout flag (bit 0) sets and the block returns to idle. With reload value N, the flag becomes visible after the (N+1)th clock edge following the START write.
- R4: A RESTART write (offset 4) whose data equals the secure counter reloads the timer. A mismatching value sets the miscompare flag (bit 1) and leaves the timer counting down.
- R5: A STOP write (offset 3) returns the block to idle. If the data differs from the secure counter, the miscompare flag (bit 1) is also set.
- R6: While active, writes to ADD (5) and SUB (9) add or subtract the data modulo 2^32. Any write to offsets 6/7/8 adds 1/16/256, and any write to offsets 10/11/12 subtracts 1/16/256.
- R7: A write to any add, subtract, RESTART or STOP offset while idle sets the sequence flag (bit 2) and has no other effect; for example, the timer is not reloaded.
- R8: A CONTROL write (offset 0) is rejected, and the control flag (bit 3) is set, when the block is active or when any 3-bit action field holds a code other than 1, 2 or 4.
- R9: CONTROL layout: action fields of 3 bits each at bit 3*k for k = timeout 0, miscompare 1, sequence 2, control 3, state 4, address 5; pause enable at bit 18; halt enable at bit 19; lock at bit 20. Once the lock bit is written as 1, later CONTROL writes are ignored without a fault until reset.
- R10: The timer holds its value while pause_in is high with the pause enable set, or while dbg_halt_in is high with the halt enable set. Either input has no effect when its enable is clear.
- R11: A read or write to any offset of 16 or above sets the address flag (bit 5).
- R12: Flags are sticky and cleared by writing 1 to their bit in FLAGS (offset 13). irq_req is high while any set flag has action code 4. rst_req is high while any set flag has action code 2. Code 1 raises nothing.
- R13: PERSIST (offset 14) reads back the last value written and is not changed by faults or by flag clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Word offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from bus_addr |
| pause_in | input | 1 | Interrupt-pause request input |
| dbg_halt_in | input | 1 | Debug-halt input |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
The embedded assertions check several properties on every cycle. The timer holds when frozen and drops by exactly one when running. Flags stay set until cleared and always set on their event. A reset request never appears without a raised flag. CONTROL never changes once locked. START and STOP always move the state as intended. The directed scenarios cover what only end-to-end sequences can show: whether add/subtract arithmetic, including wraparound, keeps the counter in agreement with the expected value, the exact timeout cycle, reload on a matching restart, rejection of bad control codes, and how each flag is mapped onto the two request outputs.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

   localparam int NCLS = 6;   // fault classes
   localparam int NREG = 16;  // mapped word offsets
   localparam int ACTW = 3;

   // fault class indices; POR flag sits above them
   localparam int FC_TMO = 0;
   localparam int FC_MIS = 1;
   localparam int FC_SEQ = 2;
   localparam int FC_CTL = 3;
   localparam int FC_STA = 4;
   localparam int FC_ADR = 5;
   localparam int FL_POR = NCLS;

   localparam logic [ACTW-1:0] ACT_NONE = 3'd1;
   localparam logic [ACTW-1:0] ACT_RST  = 3'd2;
   localparam logic [ACTW-1:0] ACT_IRQ  = 3'd4;

   typedef enum logic [3:0] {
      OFS_CTRL    = 4'd0,  OFS_RELOAD  = 4'd1,  OFS_START   = 4'd2,
      OFS_STOP    = 4'd3,  OFS_RESTART = 4'd4,  OFS_ADD     = 4'd5,
      OFS_ADD1    = 4'd6,  OFS_ADD16   = 4'd7,  OFS_ADD256  = 4'd8,
      OFS_SUB     = 4'd9,  OFS_SUB1    = 4'd10, OFS_SUB16   = 4'd11,
      OFS_SUB256  = 4'd12, OFS_FLAGS   = 4'd13, OFS_PERSIST = 4'd14,
      OFS_TIMER   = 4'd15
   } ofs_e;

   typedef struct packed {
      logic                             lock;
      logic                             halt_en;
      logic                             pause_en;
      logic [NCLS-1:0][ACTW-1:0]        act;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

   typedef enum logic [0:0] { ST_IDLE = 1'b0, ST_RUN = 1'b1 } run_e;

   function automatic ctrl_t ctrl_default();
      ctrl_t c;
      c.lock     = 1'b0;
      c.halt_en  = 1'b0;
      c.pause_en = 1'b0;
      for (int i = 0; i < NCLS; i++) c.act[i] = ACT_NONE;
      return c;
   endfunction

   function automatic logic codes_legal(ctrl_t c);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NCLS; i++)
         if (!(c.act[i] inside {ACT_NONE, ACT_RST, ACT_IRQ})) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/cfw_itimer.sv
module cfw_itimer #(
   parameter int TW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          freeze,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic [TW-1:0] cnt,
   output logic          expire
);

   initial begin
      if (TW < 2) $error("cfw_itimer: TW must be at least 2");
   end

   logic ticking;
   assign ticking = run & ~freeze & ~load;
   assign expire  = ticking & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (ticking && cnt != '0) cnt <= cnt - 1'b1;
   end

   assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && freeze && !load) |=> cnt == $past(cnt));

   assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !freeze && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/cfw_faults.sv
module cfw_faults
   import cfw_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCLS-1:0]           ev,
   input  logic [NCLS-1:0][ACTW-1:0] act,
   input  logic [NCLS:0]             clr,
   output logic [NCLS:0]             flags,
   output logic                      irq_req,
   output logic                      rst_req
);

   for (genvar g = 0; g < NCLS; g++) begin : g_cls
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[g] <= 1'b0;
         else if (ev[g])   flags[g] <= 1'b1;
         else if (clr[g])  flags[g] <= 1'b0;
      end

      assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
         ev[g] |=> flags[g]);

      assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !clr[g]) |=> flags[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags[FL_POR] <= 1'b1;
      else if (clr[FL_POR])  flags[FL_POR] <= 1'b0;
   end

   always_comb begin
      irq_req = 1'b0;
      rst_req = 1'b0;
      for (int i = 0; i < NCLS; i++) begin
         if (flags[i] && act[i] == ACT_IRQ) irq_req = 1'b1;
         if (flags[i] && act[i] == ACT_RST) rst_req = 1'b1;
      end
   end

   assert_req_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || irq_req) |-> (flags[NCLS-1:0] != '0));

endmodule

// File: rtl/cflow_wdog.sv
module cflow_wdog
   import cfw_pkg::*;
#(
   parameter int DW     = 32,
   parameter int TW     = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              pause_in,
   input  logic              dbg_halt_in,
   output logic              irq_req,
   output logic              rst_req
);

   localparam int OFS_W = $clog2(NREG);

   initial begin
      if (DW < CTRL_BITS) $error("cflow_wdog: DW too narrow for CONTROL");
      if (TW > DW)        $error("cflow_wdog: TW must not exceed DW");
      if (ADDR_W < OFS_W) $error("cflow_wdog: ADDR_W too small for register map");
   end

   // ---------------- decode ----------------
   logic [OFS_W-1:0] ofs;
   logic             mapped;
   assign ofs = bus_addr[OFS_W-1:0];

   if (ADDR_W > OFS_W) begin : g_wide_addr
      assign mapped = (bus_addr[ADDR_W-1:OFS_W] == '0);
   end else begin : g_exact_addr
      assign mapped = 1'b1;
   end

   logic [NREG-1:0] wsel;
   assign wsel = (bus_wr && mapped) ? (NREG'(1) << ofs) : '0;

   // ---------------- state ----------------
   run_e             st_q;
   ctrl_t            ctrl_q, ctrl_new;
   logic [TW-1:0]    reload_q;
   logic [DW-1:0]    persist_q;
   logic [DW-1:0]    sec_cnt;
   logic [TW-1:0]    tmr_cnt;
   logic             tmr_expire;
   logic [NCLS:0]    flags;
   logic [NCLS-1:0]  ev;

   logic active, cmp_eq, adj_any, adj_sub, freeze, tmr_load, ctrl_take;
   logic [DW-1:0] adj_amt;

   assign active   = (st_q == ST_RUN);
   assign cmp_eq   = (bus_wdata == sec_cnt);
   assign ctrl_new = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);

   always_comb begin
      adj_amt = '0;
      adj_sub = 1'b0;
      unique case (1'b1)
         wsel[OFS_ADD]:    adj_amt = bus_wdata;
         wsel[OFS_ADD1]:   adj_amt = DW'(1);
         wsel[OFS_ADD16]:  adj_amt = DW'(16);
         wsel[OFS_ADD256]: adj_amt = DW'(256);
         wsel[OFS_SUB]:    begin adj_amt = bus_wdata; adj_sub = 1'b1; end
         wsel[OFS_SUB1]:   begin adj_amt = DW'(1);    adj_sub = 1'b1; end
         wsel[OFS_SUB16]:  begin adj_amt = DW'(16);   adj_sub = 1'b1; end
         wsel[OFS_SUB256]: begin adj_amt = DW'(256);  adj_sub = 1'b1; end
         default: ;
      endcase
   end

   assign adj_any = |wsel[OFS_SUB256:OFS_ADD];

   assign freeze   = (ctrl_q.pause_en & pause_in) | (ctrl_q.halt_en & dbg_halt_in);
   assign tmr_load = (!active && wsel[OFS_START]) ||
                     (active && wsel[OFS_RESTART] && cmp_eq);
   assign ctrl_take = wsel[OFS_CTRL] && !active && !ctrl_q.lock && codes_legal(ctrl_new);

   // fault events
   assign ev[FC_TMO] = tmr_expire;
   assign ev[FC_MIS] = active && (wsel[OFS_STOP] || wsel[OFS_RESTART]) && !cmp_eq;
   assign ev[FC_SEQ] = !active && (adj_any || wsel[OFS_STOP] || wsel[OFS_RESTART]);
   assign ev[FC_CTL] = wsel[OFS_CTRL] && (active || (!ctrl_q.lock && !codes_legal(ctrl_new)));
   assign ev[FC_STA] = active && wsel[OFS_START];
   assign ev[FC_ADR] = (bus_wr || bus_rd) && !mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ctrl_q    <= ctrl_default();
         reload_q  <= '0;
         persist_q <= '0;
         sec_cnt   <= '0;
      end else begin
         if (!active && wsel[OFS_START])                   st_q <= ST_RUN;
         else if (active && (wsel[OFS_STOP] || tmr_expire)) st_q <= ST_IDLE;

         if (ctrl_take)            ctrl_q    <= ctrl_new;
         if (wsel[OFS_RELOAD])     reload_q  <= bus_wdata[TW-1:0];
         if (wsel[OFS_PERSIST])    persist_q <= bus_wdata;

         if (!active && wsel[OFS_START])  sec_cnt <= bus_wdata;
         else if (active && adj_any)      sec_cnt <= adj_sub ? sec_cnt - adj_amt
                                                             : sec_cnt + adj_amt;
      end
   end

   cfw_itimer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active),
      .freeze   (freeze),
      .load     (tmr_load),
      .load_val (reload_q),
      .cnt      (tmr_cnt),
      .expire   (tmr_expire)
   );

   cfw_faults u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .act     (ctrl_q.act),
      .clr     (wsel[OFS_FLAGS] ? bus_wdata[NCLS:0] : '0),
      .flags   (flags),
      .irq_req (irq_req),
      .rst_req (rst_req)
   );

   always_comb begin
      bus_rdata = '0;
      if (mapped) begin
         case (ofs)
            OFS_CTRL:    bus_rdata = DW'(ctrl_q);
            OFS_RELOAD:  bus_rdata = DW'(reload_q);
            OFS_FLAGS:   bus_rdata = DW'(flags);
            OFS_PERSIST: bus_rdata = persist_q;
            OFS_TIMER:   bus_rdata = DW'(tmr_cnt);
            default:     bus_rdata = '0;
         endcase
      end
   end

   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.lock |=> $stable(ctrl_q));

   assert_start_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && wsel[OFS_START]) |=> active);

   assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wsel[OFS_STOP]) |=> !active);

   assert_ctrl_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wsel[OFS_CTRL]) |=> $stable(ctrl_q));

endmodule

// File: tb/cflow_wdog_tb_top.sv
module cflow_wdog_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pause_in = 1'b0, dbg_halt_in = 1'b0;
   logic        irq_req, rst_req;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   cflow_wdog dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pause_in(pause_in), .dbg_halt_in(dbg_halt_in),
      .irq_req(irq_req), .rst_req(rst_req)
   );

   localparam logic [4:0] A_CTRL = 0, A_RELOAD = 1, A_START = 2, A_STOP = 3,
      A_RESTART = 4, A_ADD = 5, A_ADD1 = 6, A_ADD16 = 7, A_ADD256 = 8, A_SUB = 9,
      A_SUB1 = 10, A_SUB16 = 11, A_SUB256 = 12, A_FLAGS = 13, A_PERSIST = 14,
      A_TIMER = 15;

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] mkctrl(logic [2:0] t, logic [2:0] m, logic [2:0] s,
                                          logic [2:0] c, logic [2:0] st, logic [2:0] a,
                                          logic p, logic h, logic l);
      return {11'b0, l, h, p, a, st, c, s, m, t};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic clear_flags();
      wr(A_FLAGS, 32'h7F);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_FLAGS, v); check("R1 flags", v, 32'h40);
      rd(A_CTRL, v);  check("R1 ctrl", v, 32'h9249);
      check("R1 irq", {31'b0, irq_req}, 0);
      check("R1 rst", {31'b0, rst_req}, 0);
   endtask

   task automatic t_counter();
      logic [31:0] v;
      clear_flags();
      wr(A_RELOAD, 1000);
      wr(A_START, 100);
      wr(A_ADD, 5); wr(A_ADD1, 0); wr(A_ADD16, 0); wr(A_ADD256, 0);
      wr(A_SUB, 2); wr(A_SUB1, 0); wr(A_SUB16, 0); wr(A_SUB256, 0);
      wr(A_STOP, 103);
      rd(A_FLAGS, v); check("R6 add/sub chain matches", v, 0);
      wr(A_START, 0);
      wr(A_SUB1, 7);
      wr(A_STOP, 32'hFFFF_FFFF);
      rd(A_FLAGS, v); check("R6 wraparound", v, 0);
      wr(A_ADD1, 0);
      rd(A_FLAGS, v); check("R5 stop returns idle", v[2], 1);
      clear_flags();
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      wr(A_RELOAD, 5);
      wr(A_START, 3);
      repeat (4) @(negedge clk);
      rd(A_FLAGS, v); check("R3 no timeout yet", v, 0);
      rd(A_FLAGS, v); check("R3 timeout flag", v, 32'h1);
      check("R12 code 1 no irq", {31'b0, irq_req}, 0);
      rd(A_TIMER, v); check("R3 timer at zero", v, 0);
      wr(A_RESTART, 3);
      rd(A_TIMER, v); check("R7 restart in idle no reload", v, 0);
      rd(A_FLAGS, v); check("R7 sequence flag", v, 32'h5);
      clear_flags();
   endtask

   task automatic t_restart();
      logic [31:0] v, t1, t2;
      wr(A_RELOAD, 20);
      wr(A_START, 9);
      repeat (3) @(negedge clk);
      wr(A_RESTART, 9);
      rd(A_TIMER, v); check("R4 match reloads", v, 19);
      rd(A_TIMER, t1);
      wr(A_RESTART, 8);
      rd(A_TIMER, t2); check("R4 mismatch no reload", t2, t1 - 4);
      rd(A_FLAGS, v); check("R4 miscompare flag", v, 32'h2);
      clear_flags();
      wr(A_STOP, 10);
      rd(A_FLAGS, v); check("R5 stop mismatch", v, 32'h2);
      clear_flags();
   endtask

   task automatic t_state();
      logic [31:0] v;
      wr(A_RELOAD, 1000);
      wr(A_START, 50);
      wr(A_START, 60);
      wr(A_STOP, 50);
      rd(A_FLAGS, v); check("R2 start while active ignored", v, 32'h10);
      clear_flags();
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(A_START, 1);
      wr(A_CTRL, mkctrl(4, 1, 1, 1, 1, 1, 0, 0, 0));
      rd(A_CTRL, v); check("R8 busy write rejected", v, 32'h9249);
      rd(A_FLAGS, v); check("R8 control flag busy", v, 32'h8);
      wr(A_STOP, 1);
      clear_flags();
      wr(A_CTRL, mkctrl(3, 1, 1, 1, 1, 1, 0, 0, 0));
      rd(A_CTRL, v); check("R8 bad code rejected", v, 32'h9249);
      rd(A_FLAGS, v); check("R8 control flag code", v, 32'h8);
      clear_flags();
   endtask

   task automatic t_freeze();
      logic [31:0] t1, t2;
      wr(A_CTRL, mkctrl(1, 1, 1, 1, 1, 1, 1, 0, 0));
      wr(A_RELOAD, 1000);
      wr(A_START, 1);
      pause_in = 1'b1;
      rd(A_TIMER, t1); rd(A_TIMER, t2); check("R10 pause freezes", t2, t1);
      pause_in = 1'b0; dbg_halt_in = 1'b1;
      rd(A_TIMER, t1); rd(A_TIMER, t2); check("R10 halt ignored when disabled", t2, t1 - 2);
      dbg_halt_in = 1'b0;
      wr(A_STOP, 1);
      wr(A_CTRL, mkctrl(1, 1, 1, 1, 1, 1, 0, 1, 0));
      wr(A_START, 1);
      pause_in = 1'b1;
      rd(A_TIMER, t1); rd(A_TIMER, t2); check("R10 pause ignored when disabled", t2, t1 - 2);
      pause_in = 1'b0; dbg_halt_in = 1'b1;
      rd(A_TIMER, t1); rd(A_TIMER, t2); check("R10 halt freezes", t2, t1);
      dbg_halt_in = 1'b0;
      wr(A_STOP, 1);
      clear_flags();
   endtask

   task automatic t_addr();
      logic [31:0] v;
      rd(5'd20, v);
      rd(A_FLAGS, v); check("R11 unmapped read", v, 32'h20);
      clear_flags();
      wr(5'd31, 32'h1);
      rd(A_FLAGS, v); check("R11 unmapped write", v, 32'h20);
      clear_flags();
   endtask

   task automatic t_actions();
      logic [31:0] v;
      wr(A_CTRL, mkctrl(1, 4, 2, 1, 1, 1, 0, 0, 0));
      wr(A_START, 5);
      wr(A_STOP, 6);
      check("R12 irq from miscompare", {31'b0, irq_req}, 1);
      check("R12 no rst yet", {31'b0, rst_req}, 0);
      wr(A_ADD1, 0);
      check("R12 rst from sequence", {31'b0, rst_req}, 1);
      wr(A_FLAGS, 32'h2);
      check("R12 irq cleared", {31'b0, irq_req}, 0);
      check("R12 rst kept", {31'b0, rst_req}, 1);
      clear_flags();
      rd(A_FLAGS, v); check("R12 all cleared", v, 0);
      check("R12 rst cleared", {31'b0, rst_req}, 0);
   endtask

   task automatic t_persist();
      logic [31:0] v;
      wr(A_PERSIST, 32'hA5A5_1234);
      wr(A_SUB16, 0);
      clear_flags();
      rd(A_PERSIST, v); check("R13 persistent word", v, 32'hA5A5_1234);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(A_CTRL, mkctrl(4, 1, 1, 1, 1, 1, 0, 0, 1));
      wr(A_CTRL, mkctrl(1, 1, 1, 1, 1, 1, 0, 0, 0));
      rd(A_CTRL, v); check("R9 locked ctrl", v, mkctrl(4, 1, 1, 1, 1, 1, 0, 0, 1));
      rd(A_FLAGS, v); check("R9 no fault on locked write", v, 0);
      do_reset();
      rd(A_CTRL, v); check("R9 reset unlocks", v, 32'h9249);
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_counter();
      t_timeout();
      t_restart();
      t_state();
      t_ctrl();
      t_freeze();
      t_addr();
      t_actions();
      t_persist();
      t_lock();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule